// File: doc/BRIEF.md
# Two-State Viterbi Decoder with Path-Merge Monitor

This block recovers a stream of antipodal (BPSK) data bits that passed through a channel with one symbol of memory: every received value is the current symbol plus a fixed fraction of the one before it, plus noise. One signed quantized sample arrives per clock, qualified by a valid strobe. The block runs a trellis with two states, where the state is the previous data bit. It keeps two running path costs and a short sliding window of survivor pointers, and it emits one decided bit for every accepted sample once the window is full.

Alongside the decoder, a monitor watches the newest trellis stage. It checks whether both survivors point back to the same previous state. Each stage where the two survivors disagree is counted. When that count grows past the traceback depth, the monitor pulses a flag for one cycle and restarts its count. A system can use the flag as a sign that the decisions are being made on paths that have not merged.

Top module: `vit2_decoder`

## Requirements
- R1: After a synchronous reset, `out_valid` and `conv_flag` are 0, both path costs are 0, the survivor window is cleared and the non-merge counter is 0.
- R2: For a transition from previous state p into new state b, the expected noiseless sample is (b ? +AMP : -AMP) + (p ? +AMP>>ISI_SH : -(AMP>>ISI_SH)). The branch cost is the absolute difference between the received sample and that value.
- R3: For each new state b, the candidate through previous state 0 is cost0 + branch(0,b) and through state 1 is cost1 + branch(1,b). The smaller one wins, and a tie selects state 0. The pointer bit for state b is 1 when state 1 wins. Both new costs are then reduced by the smaller of the two, so after every accepted sample at least one cost is 0.
- R4: A cycle with `in_valid` low changes no cost, pointer or counter, and drives `out_valid` and `conv_flag` low in the next cycle.
- R5: Traceback starts at the new state with the strictly smaller cost (state 0 on a tie). It follows TB_LEN-1 pointers from newest to older stages and outputs the state reached. That state is the bit of the sample accepted TB_LEN-1 samples earlier.
- R6: With noiseless samples that start from a previous bit of 0 after reset, every decided bit equals the bit sent TB_LEN-1 accepted samples earlier.
- R7: A stage whose two pointer bits differ increments the non-merge counter. A stage whose pointer bits are equal leaves the counter unchanged. When an increment would take the count above TB_LEN, `conv_flag` is high for that one cycle and the count returns to 0. With constant zero samples after reset, the flag fires every TB_LEN+1 samples.
- R8: `out_valid` rises first on the TB_LEN-th accepted sample after reset, and only for cycles that accept a sample.
- R9: Full-scale samples (the most negative and most positive codes) are decoded without cost overflow and follow R2 and R3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; one trellis stage per high cycle |
| in_sample | input | SW | Signed two's-complement quantized sample |
| out_valid | output | 1 | Decided bit is valid this cycle |
| out_bit | output | 1 | Decided bit for the sample TB_LEN-1 samples back |
| conv_flag | output | 1 | One-cycle pulse when the non-merge count passes TB_LEN |

## Verification
All three results are registered on the same rising edge that accepts a sample. The decided bit for sample n therefore appears with sample n+TB_LEN-1, one clock after that later sample is driven, and the flag and valid appear one clock after the stage that causes them. The bench drives each sample on a falling edge. On the next falling edge it compares `out_valid`, `out_bit` and `conv_flag` against a behavioural model that it updated when it drove the sample. This keeps every comparison exactly one edge behind its stimulus, including across idle cycles and resets.

// File: rtl/vit_pkg.sv
package vit_pkg;
  // Pointer pair for one stage: bit s is the predecessor of state s.
  typedef logic [1:0] surv_t;

  // Index of a branch cost for predecessor p and new state b.
  function automatic int br_idx(input int p, input int b);
    return 2 * p + b;
  endfunction
endpackage

// File: rtl/vit_branch_unit.sv
module vit_branch_unit #(
  parameter int SW     = 8,
  parameter int AMP    = 32,
  parameter int ISI_SH = 1,
  parameter int BMW    = SW + 2
) (
  input  logic signed [SW-1:0]  sample,
  output logic [3:0][BMW-1:0]   bm
);
  localparam int EW  = BMW;
  localparam int ISI = AMP >>> ISI_SH;

  logic signed [EW-1:0] sx;
  assign sx = EW'(sample);

  for (genvar g = 0; g < 4; g++) begin : g_br
    localparam int P  = g / 2;
    localparam int B  = g % 2;
    localparam int EV = (B == 1 ? AMP : -AMP) + (P == 1 ? ISI : -ISI);
    logic signed [EW-1:0] diff;
    assign diff  = sx - EW'(EV);
    assign bm[g] = diff[EW-1] ? BMW'(-diff) : BMW'(diff);
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs #(
  parameter int BMW = 10,
  parameter int PMW = BMW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [3:0][BMW-1:0]  bm,
  output vit_pkg::surv_t       sel,
  output logic                 start_state
);
  import vit_pkg::*;
  localparam int CW = PMW + 1;

  logic [PMW-1:0] pm0, pm1;
  logic [CW-1:0]  c00, c10, c01, c11, n0, n1, mn;

  always_comb begin
    c00 = CW'(pm0) + CW'(bm[br_idx(0, 0)]);
    c10 = CW'(pm1) + CW'(bm[br_idx(1, 0)]);
    c01 = CW'(pm0) + CW'(bm[br_idx(0, 1)]);
    c11 = CW'(pm1) + CW'(bm[br_idx(1, 1)]);
    sel[0] = (c10 < c00);
    sel[1] = (c11 < c01);
    n0 = sel[0] ? c10 : c00;
    n1 = sel[1] ? c11 : c01;
    start_state = (n1 < n0);
    mn = start_state ? n1 : n0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm0 <= '0;
      pm1 <= '0;
    end else if (in_valid) begin
      pm0 <= PMW'(n0 - mn);
      pm1 <= PMW'(n1 - mn);
    end
  end

  // R3
  norm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (pm0 == '0 || pm1 == '0));
  // R4
  cost_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pm0) && $stable(pm1)));
endmodule

// File: rtl/vit_window.sv
module vit_window #(
  parameter int TB_LEN = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  vit_pkg::surv_t  sel,
  input  logic            start_state,
  output logic            out_valid,
  output logic            out_bit
);
  import vit_pkg::*;
  localparam int FW = (TB_LEN > 2) ? $clog2(TB_LEN) : 1;

  surv_t [TB_LEN-1:0] win;
  surv_t [TB_LEN-1:0] wn;
  logic  [FW-1:0]     fill;
  logic               tb_bit;

  always_comb begin
    wn = {win[TB_LEN-2:0], sel};
    tb_bit = start_state;
    for (int k = 0; k < TB_LEN - 1; k++) tb_bit = wn[k][tb_bit];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid && (fill == FW'(TB_LEN - 1));
      if (in_valid) begin
        win     <= wn;
        out_bit <= tb_bit;
        if (fill != FW'(TB_LEN - 1)) fill <= fill + 1'b1;
      end
    end
  end

  // R8
  out_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(TB_LEN - 1));
endmodule

// File: rtl/vit_conv_mon.sv
module vit_conv_mon #(
  parameter int TB_LEN = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  vit_pkg::surv_t  sel,
  output logic            conv_flag
);
  localparam int CW = $clog2(TB_LEN + 1);

  logic [CW-1:0] cnt;
  logic          split;
  assign split = sel[0] ^ sel[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      conv_flag <= 1'b0;
    end else begin
      conv_flag <= 1'b0;
      if (in_valid && split) begin
        if (cnt == CW'(TB_LEN)) begin
          cnt       <= '0;
          conv_flag <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TB_LEN));
  // R7
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_flag |=> !conv_flag);
  // R4
  flag_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    conv_flag |-> ($past(in_valid) && cnt == '0));
endmodule

// File: rtl/vit2_decoder.sv
module vit2_decoder #(
  parameter int SW     = 8,
  parameter int AMP    = 32,
  parameter int ISI_SH = 1,
  parameter int TB_LEN = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  output logic                 out_valid,
  output logic                 out_bit,
  output logic                 conv_flag
);
  import vit_pkg::*;
  localparam int BMW = SW + 2;
  localparam int PMW = BMW + 1;

  logic [3:0][BMW-1:0] bm;
  surv_t               sel;
  logic                start_state;

  vit_branch_unit #(.SW(SW), .AMP(AMP), .ISI_SH(ISI_SH), .BMW(BMW)) u_br (
    .sample (in_sample),
    .bm     (bm)
  );

  vit_acs #(.BMW(BMW), .PMW(PMW)) u_acs (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .bm          (bm),
    .sel         (sel),
    .start_state (start_state)
  );

  vit_window #(.TB_LEN(TB_LEN)) u_win (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .sel         (sel),
    .start_state (start_state),
    .out_valid   (out_valid),
    .out_bit     (out_bit)
  );

  vit_conv_mon #(.TB_LEN(TB_LEN)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sel       (sel),
    .conv_flag (conv_flag)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !conv_flag));
endmodule

// File: tb/tb_vit2_decoder.sv
module tb_vit2_decoder;
  localparam int SW = 8, AMP = 32, ISI_SH = 1, L = 6;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic out_valid, out_bit, conv_flag;

  int checks = 0, errors = 0;
  // behavioural model state
  int pm0, pm1, fill, cnt;
  int pq0[$], pq1[$], txq[$];
  int exp_v, exp_b, exp_f, exp_clean, exp_tx;
  int clean_run, prevtx, flags_seen;
  logic [31:0] lf = 32'h1234_5678;

  always #10 clk = ~clk;

  vit2_decoder #(.SW(SW), .AMP(AMP), .ISI_SH(ISI_SH), .TB_LEN(L)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_bit(out_bit), .conv_flag(conv_flag));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ideal(int p, int b);
    return (b != 0 ? AMP : -AMP) + (p != 0 ? (AMP >>> ISI_SH) : -(AMP >>> ISI_SH));
  endfunction

  function automatic int absv(int x);
    return x < 0 ? -x : x;
  endfunction

  function automatic int rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return int'(lf & 32'h7fff_ffff);
  endfunction

  task automatic model_reset();
    pm0 = 0; pm1 = 0; fill = 0; cnt = 0;
    pq0.delete(); pq1.delete(); txq.delete();
    exp_v = 0; exp_b = 0; exp_f = 0; exp_clean = 0; exp_tx = 0;
    clean_run = 1; prevtx = 0;
  endtask

  task automatic model(int v, int q, int clean_now, int txbit);
    int c00, c10, c01, c11, p0, p1, n0, n1, mn, st;
    if (v == 0) begin
      exp_v = 0; exp_f = 0;
      return;
    end
    if (clean_now == 0) clean_run = 0;
    c00 = pm0 + absv(q - ideal(0, 0));
    c10 = pm1 + absv(q - ideal(1, 0));
    c01 = pm0 + absv(q - ideal(0, 1));
    c11 = pm1 + absv(q - ideal(1, 1));
    p0 = (c10 < c00) ? 1 : 0;
    p1 = (c11 < c01) ? 1 : 0;
    n0 = p0 ? c10 : c00;
    n1 = p1 ? c11 : c01;
    st = (n1 < n0) ? 1 : 0;
    mn = st ? n1 : n0;
    pm0 = n0 - mn; pm1 = n1 - mn;
    pq0.push_front(p0); pq1.push_front(p1); txq.push_front(txbit);
    if (pq0.size() > L) begin void'(pq0.pop_back()); void'(pq1.pop_back()); end
    if (txq.size() > L) void'(txq.pop_back());
    if (pq0.size() >= L) begin
      for (int k = 0; k < L - 1; k++) st = (st != 0) ? pq1[k] : pq0[k];
    end
    if (fill < L) fill++;
    exp_v = (fill >= L) ? 1 : 0;
    if (exp_v != 0) exp_b = st;
    exp_clean = (exp_v != 0 && clean_run != 0) ? 1 : 0;
    exp_tx = (txq.size() >= L) ? txq[L-1] : 0;
    exp_f = 0;
    if (p0 != p1) begin
      cnt++;
      if (cnt > L) begin exp_f = 1; cnt = 0; end
    end
  endtask

  task automatic compare();
    chk("R8 out_valid timing", int'(out_valid), exp_v);
    if (exp_v != 0) chk("R5 R2 R3 traceback bit", int'(out_bit), exp_b);
    if (exp_clean != 0) chk("R6 noiseless bit", int'(out_bit), exp_tx);
    chk("R7 conv_flag", int'(conv_flag), exp_f);
    if (conv_flag) flags_seen++;
  endtask

  task automatic step(int v, int q, int clean_now, int txbit);
    int qc;
    @(negedge clk);
    compare();
    qc = q > 127 ? 127 : (q < -128 ? -128 : q);
    in_valid = (v != 0);
    in_sample = SW'(qc);
    model(v, qc, clean_now, txbit);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state visible at the ports
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 conv_flag after reset", int'(conv_flag), 0);
  endtask

  task automatic send_clean(int b);
    step(1, ideal(prevtx, b), 1, b);
    prevtx = b;
  endtask

  task automatic send_noisy(int b, int span);
    step(1, ideal(prevtx, b) + (rnd() % (2 * span + 1)) - span, 0, b);
    prevtx = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R6 R8: noiseless random bits with idle gaps (R4)
    for (int i = 0; i < 40; i++) begin
      send_clean(rnd() & 1);
      if (i % 9 == 4) step(0, 77, 1, 0);
    end
    // R6: all zeros, then alternating
    for (int i = 0; i < 20; i++) send_clean(0);
    for (int i = 0; i < 20; i++) send_clean(i & 1);
    // R4: idle run must leave outputs low and state intact
    for (int i = 0; i < 5; i++) step(0, -100, 1, 0);
    for (int i = 0; i < 10; i++) send_clean(1);
    // R7: constant zero samples from reset -> flag every L+1 samples
    do_reset();
    flags_seen = 0;
    for (int i = 0; i < 4 * (L + 1); i++) step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R7 flag count on zero input", flags_seen, 4);
    // R2 R3 R5: moderate and heavy noise
    do_reset();
    for (int i = 0; i < 300; i++) send_noisy(rnd() & 1, 40);
    for (int i = 0; i < 300; i++) send_noisy(rnd() & 1, 120);
    // R9: full-scale samples
    for (int i = 0; i < 60; i++) step(1, (rnd() & 1) ? 127 : -128, 0, 0);
    // R1: reset in the middle of traffic
    do_reset();
    for (int i = 0; i < 12; i++) send_clean(rnd() & 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule